// File: doc/BRIEF.md
# Synchronous SRAM Read/Write Datapath with Selectable Output Latency

This block is a synthesizable model of a synchronous static RAM datapath. On each rising clock edge it captures the address, the three chip selects, the write controls and the write data. The write controls are a global write, a byte-write gate and one enable per byte lane. A selected write updates the array at that edge, either the whole word or the chosen byte lanes. A selected read returns a full word.

A static mode input sets the read latency. In flow-through mode the word comes straight from the array and appears after the capture edge. In pipelined mode the word passes through an output register and appears one edge later. A deselect or a write shuts the output drivers off at the same point in the pipeline where a read would have switched them on, so the drivers never stay on for an extra cycle after a deselect.

The output enable and the sleep input are asynchronous and can turn the drivers off at any time. While sleep is high the array keeps its contents and ignores every access. A separate drive indicator stands in for the tristate control of a bidirectional bus.

Top module: `sram_sync_top`

## Requirements
- R1: A cycle selects the device only when `selAN`=0, `selB`=1 and `selCN`=0 at the edge. Any other combination is a deselect: the array is not written and no read is captured.
- R2: `gWrN`=0 on a selected cycle writes all byte lanes with `wData`, whatever `bWrN` and `byteEnN` are.
- R3: With `gWrN`=1 and `bWrN`=0, every lane i whose `byteEnN[i]` is 0 is written from `wData[8i+7:8i]`. Lanes whose enable is 1 keep their old contents.
- R4: A selected cycle is a read when `gWrN`=1 and either `bWrN`=1 or all four `byteEnN` bits are 1. A read drives all 32 output bits.
- R5: With `pipeMode`=0 (flow-through), the word of a read captured at edge n is on `dout` from just after edge n until edge n+1.
- R6: With `pipeMode`=1 (pipelined), the word of a read captured at edge n is on `dout` from just after edge n+1 until edge n+2. It is the array content as of edge n+1.
- R7: After an edge, `doutDrive` follows the command captured at that edge in flow-through mode, and the command one edge earlier in pipelined mode. A deselect or a write in that slot leaves the drivers off.
- R8: `oeN`=1 or `sleep`=1 forces `doutDrive` to 0 at once, without waiting for a clock edge.
- R9: While `sleep`=1 at an edge, no write and no read capture take place, and the array keeps its contents.
- R10: Whenever `doutDrive` is 0, `dout` is all zeros.
- R11: A word written at edge n is returned by a read of the same address at edge n+1, with the latency of the current mode.
- R12: While `rstN` is low and after it is released, `doutDrive` is 0 until a read is captured. Reset does not clear the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low reset of the control pipeline |
| pipeMode | input | 1 | 1 = pipelined reads, 0 = flow-through reads |
| addr | input | ADDR_W | Word address |
| selAN | input | 1 | Chip select, active low |
| selB | input | 1 | Chip select, active high |
| selCN | input | 1 | Chip select, active low |
| gWrN | input | 1 | Global write, active low |
| bWrN | input | 1 | Byte-write gate, active low |
| byteEnN | input | NBYTES | Per-lane write enables, active low |
| wData | input | 8*NBYTES | Write data |
| oeN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous standby, active high |
| dout | output | 8*NBYTES | Read data, zero when not driven |
| doutDrive | output | 1 | 1 when the output drivers are on |

## Verification
The bench builds the block with `ADDR_W`=4, which gives 16 words of four lanes. This small size lets every address be written and read back in both output modes. Using the address as the lane-enable pattern covers all 16 byte-enable masks, including the all-ones mask that turns a byte write into a read. Each chip select is made inactive on its own, and write-then-read pairs on the same address are run in both modes. Sleep and output-enable cycles are mixed in, so the latency, drive-off and retention behaviour is checked against a reference array in both modes.

// File: rtl/sram_dp_pkg.sv
package sram_dp_pkg;

  // Strobes issued by the control to the datapath for the current edge.
  typedef struct packed {
    logic wrEn;     // selected write cycle
    logic rdCap;    // selected read cycle
    logic deselect; // not selected (includes sleep)
  } sramStrobe_t;

endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_dp_pkg::*;
#(
  parameter int unsigned NBYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pipeMode,
  input  logic              selAN,
  input  logic              selB,
  input  logic              selCN,
  input  logic              gWrN,
  input  logic              bWrN,
  input  logic [NBYTES-1:0] byteEnN,
  input  logic              oeN,
  input  logic              sleep,
  output sramStrobe_t       strb,
  output logic [NBYTES-1:0] wrMask,
  output logic              driveOn
);

  logic selected;
  logic isWrite;
  logic rdStage1;   // read captured at the latest edge
  logic rdStage2;   // read captured one edge earlier

  always_comb begin
    selected      = !selAN && selB && !selCN && !sleep;
    isWrite       = !gWrN || (!bWrN && !(&byteEnN));
    strb.wrEn     = selected && isWrite;
    strb.rdCap    = selected && !isWrite;
    strb.deselect = !selected;
    wrMask        = !gWrN ? {NBYTES{1'b1}} : ~byteEnN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdStage1 <= 1'b0;
      rdStage2 <= 1'b0;
    end else begin
      rdStage1 <= strb.rdCap;
      rdStage2 <= rdStage1;
    end
  end

  assign driveOn = (pipeMode ? rdStage2 : rdStage1) && !oeN && !sleep;

  // R7: a deselect or write owns its output slot and keeps drivers off
  p_slot_off_ft_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.deselect || strb.wrEn) && !pipeMode) |=> !driveOn);

  p_slot_off_pipe_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.deselect || strb.wrEn) && pipeMode) |=> ##1 !driveOn);

  // R5: a flow-through read turns the drivers on right after its capture edge
  p_ft_on_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdCap && !pipeMode && !oeN) |=> (driveOn || oeN || sleep));

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_dp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NBYTES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pipeMode,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [8*NBYTES-1:0] wData,
  input  sramStrobe_t         strb,
  input  logic [NBYTES-1:0]   wrMask,
  input  logic                driveOn,
  output logic [8*NBYTES-1:0] dout
);

  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned DATA_W = 8 * NBYTES;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] ftWord;
  logic [DATA_W-1:0] outReg;

  // Address register: updated on every selected access.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (strb.wrEn || strb.rdCap) begin
      addrReg <= addr;
    end
  end

  // One storage array per byte lane.
  for (genvar g = 0; g < NBYTES; g++) begin : gLane
    logic [7:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strb.wrEn && wrMask[g]) begin
        laneMem[addr] <= wData[8*g +: 8];
      end
    end

    assign ftWord[8*g +: 8] = laneMem[addrReg];
  end

  // Output register used by the pipelined read path.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
    end else begin
      outReg <= ftWord;
    end
  end

  always_comb begin
    if (!driveOn) begin
      dout = '0;
    end else if (pipeMode) begin
      dout = outReg;
    end else begin
      dout = ftWord;
    end
  end

  // R2: a full-word write is visible on the array read port after its edge
  p_full_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && (&wrMask)) |=> (ftWord == $past(wData)));

  // R6: pipelined output lags the array read port by one edge
  p_pipe_lag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (driveOn && pipeMode) |-> (dout == $past(ftWord)));

endmodule

// File: rtl/sram_sync_top.sv
module sram_sync_top
  import sram_dp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NBYTES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pipeMode,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                selAN,
  input  logic                selB,
  input  logic                selCN,
  input  logic                gWrN,
  input  logic                bWrN,
  input  logic [NBYTES-1:0]   byteEnN,
  input  logic [8*NBYTES-1:0] wData,
  input  logic                oeN,
  input  logic                sleep,
  output logic [8*NBYTES-1:0] dout,
  output logic                doutDrive
);

  sramStrobe_t       strb;
  logic [NBYTES-1:0] wrMask;
  logic              driveOn;

  sram_ctrl #(.NBYTES(NBYTES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .pipeMode (pipeMode),
    .selAN    (selAN),
    .selB     (selB),
    .selCN    (selCN),
    .gWrN     (gWrN),
    .bWrN     (bWrN),
    .byteEnN  (byteEnN),
    .oeN      (oeN),
    .sleep    (sleep),
    .strb     (strb),
    .wrMask   (wrMask),
    .driveOn  (driveOn)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .pipeMode (pipeMode),
    .addr     (addr),
    .wData    (wData),
    .strb     (strb),
    .wrMask   (wrMask),
    .driveOn  (driveOn),
    .dout     (dout)
  );

  assign doutDrive = driveOn;

endmodule

// File: tb/tb_sram_sync_top.sv
`timescale 1ns/1ps
module tb_sram_sync_top;

  localparam int AW = 4;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic          pipeMode;
  logic [AW-1:0] addr;
  logic          selAN, selB, selCN, gWrN, bWrN, oeN, sleep;
  logic [3:0]    byteEnN;
  logic [31:0]   wData;
  logic [31:0]   dout;
  logic          doutDrive;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0]   refMem [NW];
  logic          curRd, prevRd;
  logic [AW-1:0] curAddr;
  logic [31:0]   pipeData;

  always #2.5 clk = ~clk;

  sram_sync_top #(.ADDR_W(AW), .NBYTES(4)) dut (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .addr(addr),
    .selAN(selAN), .selB(selB), .selCN(selCN), .gWrN(gWrN), .bWrN(bWrN),
    .byteEnN(byteEnN), .wData(wData), .oeN(oeN), .sleep(sleep),
    .dout(dout), .doutDrive(doutDrive)
  );

  function automatic logic [31:0] pat(input int a, input int k);
    return (32'h9E3779B9 * (a + 1)) ^ (32'h01010101 * k) ^ {16'h0, a[7:0], 8'h5A};
  endfunction

  task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s drive/data got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive one cycle at a falling edge, model the rising edge, check at the next falling edge.
  task automatic doCycle(input logic [AW-1:0] a, input logic c1n, input logic c2, input logic c3n,
                         input logic gw, input logic bw, input logic [3:0] be,
                         input logic [31:0] d, input logic oe, input logic sl, input string tag);
    logic sel, isWr;
    logic [3:0] mask;
    logic expDrive;
    logic [31:0] expData;
    addr = a; selAN = c1n; selB = c2; selCN = c3n; gWrN = gw; bWrN = bw;
    byteEnN = be; wData = d; oeN = oe; sleep = sl;
    @(posedge clk);
    sel  = !c1n && c2 && !c3n && !sl;
    isWr = !gw || (!bw && be != 4'hF);
    mask = !gw ? 4'hF : ~be;
    pipeData = refMem[curAddr];
    prevRd = curRd;
    if (sel && isWr)
      for (int i = 0; i < 4; i++)
        if (mask[i]) refMem[a][8*i +: 8] = d[8*i +: 8];
    curRd = sel && !isWr;
    if (sel) curAddr = a;
    @(negedge clk);
    expDrive = (pipeMode ? prevRd : curRd) && !oe && !sl;
    expData  = !expDrive ? 32'h0 : (pipeMode ? pipeData : refMem[curAddr]);
    check(tag, {doutDrive, dout}, {expDrive, expData});
  endtask

  task automatic idle(input string tag);
    doCycle('0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 32'h0, 1'b0, 1'b0, tag);
  endtask
  task automatic rd(input int a, input logic bw, input logic [3:0] be, input string tag);
    doCycle(a[AW-1:0], 1'b0, 1'b1, 1'b0, 1'b1, bw, be, 32'hDEADBEEF, 1'b0, 1'b0, tag);
  endtask
  task automatic wrG(input int a, input logic bw, input logic [3:0] be, input logic [31:0] d,
                     input string tag);
    doCycle(a[AW-1:0], 1'b0, 1'b1, 1'b0, 1'b0, bw, be, d, 1'b0, 1'b0, tag);
  endtask
  task automatic wrB(input int a, input logic [3:0] be, input logic [31:0] d, input string tag);
    doCycle(a[AW-1:0], 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, be, d, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; pipeMode = 1'b0; addr = '0; selAN = 1'b1; selB = 1'b1; selCN = 1'b0;
    gWrN = 1'b1; bWrN = 1'b1; byteEnN = 4'hF; wData = '0; oeN = 1'b0; sleep = 1'b0;
    curRd = 1'b0; prevRd = 1'b0; curAddr = '0; pipeData = '0;
    for (int i = 0; i < NW; i++) refMem[i] = '0;
    repeat (3) @(negedge clk);
    check("R12 reset", {doutDrive, dout}, 33'h0);
    rstN = 1'b1;
    idle("R12 after reset");

    for (int m = 0; m < 2; m++) begin
      pipeMode = m[0];
      idle("R10 idle"); idle("R10 idle");
      // R2: global write ignores byte controls
      for (int a = 0; a < NW; a++) wrG(a, a[0], a[3:0], pat(a, m), "R2 global write");
      for (int a = 0; a < NW; a++) rd(a, 1'b1, a[3:0], m ? "R6 pipelined read" : "R5 flow read");
      idle("R7 deselect after read"); idle("R7 deselect");
      // R3: every lane-enable mask, all-ones mask is a read (R4)
      for (int a = 0; a < NW; a++) wrB(a, a[3:0], pat(a, m + 7), "R3 byte write");
      for (int a = 0; a < NW; a++) rd(a, 1'b0, 4'hF, "R4 read with all lanes off");
      rd(2, 1'b1, 4'h0, "R4 read ignores lane enables");
      // R11: write then read at next edge
      for (int a = 0; a < NW; a += 3) begin
        wrG(a, 1'b1, 4'hF, pat(a, m + 20), "R11 write");
        rd(a, 1'b1, 4'hF, "R11 read back");
      end
      idle("R7 flush"); idle("R7 flush");
      // R1: each chip select alone blocks access
      doCycle(4'd6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 32'h11111111, 1'b0, 1'b0, "R1 selAN");
      doCycle(4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 32'h22222222, 1'b0, 1'b0, "R1 selB");
      doCycle(4'd6, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 32'h33333333, 1'b0, 1'b0, "R1 selCN");
      doCycle(4'd6, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 32'h0, 1'b0, 1'b0, "R1 deselected read");
      rd(6, 1'b1, 4'hF, "R1 contents kept");
      rd(7, 1'b1, 4'hF, "R7 read then deselect");
      idle("R7 single-cycle deselect"); idle("R7 single-cycle deselect");
      // R8: output enable
      doCycle(4'd4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 32'h0, 1'b1, 1'b0, "R8 oeN high");
      doCycle(4'd4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 32'h0, 1'b1, 1'b0, "R8 oeN high");
      rd(4, 1'b1, 4'hF, "R8 oeN low");
      // R9: sleep blocks writes and reads, retains data
      doCycle(4'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 32'hCAFEF00D, 1'b0, 1'b1, "R9 sleep write");
      doCycle(4'd5, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 32'h0, 1'b0, 1'b1, "R9 sleep read");
      rd(5, 1'b1, 4'hF, "R9 retained");
      rd(5, 1'b1, 4'hF, "R9 retained");
      idle("R10 idle"); idle("R10 idle");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule